// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel flash device. It takes one request at a time, which is a byte program, a sector erase or a whole-chip erase. It then drives the flash pins through the command write cycles that unlock the device. The last write hands the job to the device's internal algorithm. Every bus phase is timed by counting system clocks.

After the last command write the block reads back one location over and over. During the internal operation, bit 7 of that read returns the inverse of its final value. When bit 7 matches the expected value, the block pulses `done`. If a programmable number of polling clocks runs out first, it pulses `err`. A sector erase can take a mask of sectors and erase all of them in one request.

Top module: `flash_cmd_seq`

## Requirements
- R1: The request code is 0 for program, 1 for sector erase, 2 for chip erase and 3 for reserved. A program request makes four write cycles, in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then `req_data` to `req_addr`.
- R2: A chip erase request makes six write cycles. The first five are AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h and 55h to 2AAAh. The sixth is 10h to 5555h.
- R3: A sector erase request makes the same five unlock writes as R2. It then writes 30h once for each set bit of `req_sect_mask`, in ascending sector order. The address of each of these writes is the sector index in address bits 16..14, with all lower bits at zero. A zero mask selects the sector given by `req_addr[16:14]`.
- R4: In every write cycle `fl_oe_n` is high and `fl_dq_oe` is high. `fl_we_n` stays low for at least 5 clocks and high for at least 3 clocks between writes, and one write starts at least 9 clocks after the previous one. Address and data do not change while `fl_we_n` is low or on its rising edge. Data is stable for at least 4 clocks before `fl_we_n` rises.
- R5: A polling read drives `fl_ce_n` and `fl_oe_n` low with `fl_dq_oe` low. It samples `fl_dq_i` in the last clock of its access window. It reads `req_addr` for program and chip erase, and the base of the highest selected sector for sector erase.
- R6: The operation is complete when the sampled bit 7 equals the expected value: `req_data[7]` for program, 1 for either erase. Bits 6..0 have no effect. On completion `done` is high for one clock.
- R7: Polling clocks are counted from the first polling clock. A sample that does not match, taken once that count is at least `cfg_poll_limit`, ends the operation with a one-clock `err` pulse and no `done`.
- R8: A matching sample ends the operation with `done` and not `err`, even when the count has already reached `cfg_poll_limit`.
- R9: `busy` is high from the clock after a request is accepted until the `done` or `err` clock. A request presented while `busy` is high is ignored.
- R10: A request with code 3 causes no bus activity, and `busy` stays low.
- R11: After reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, and `fl_dq_oe`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_op | input | 2 | Request code (0 program, 1 sector erase, 2 chip erase, 3 reserved) |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | 8 | Byte to program |
| req_sect_mask | input | N_SECT | Sectors to erase, one bit each |
| cfg_poll_limit | input | LIM_W | Polling timeout in clocks |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock timeout pulse |
| fl_addr | output | ADDR_W | Flash address |
| fl_dq_o | output | 8 | Flash data out |
| fl_dq_oe | output | 1 | Flash data output enable |
| fl_dq_i | input | 8 | Flash data in |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
A completion match and an expired timeout can both be true at the same polling sample. To force this, the bench sets the limit to 0 or 1, below the length of one access window, and the flash model returns the final bit 7 on the very first read. The expected result is a `done` pulse with `err` low.

The bench also runs cases where the model stays busy through many reads under a small limit, and these must end in `err`. Together the two cases show which outcome the block picks when both conditions hold.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WLO  = 3'd1,
    ST_WHI  = 3'd2,
    ST_RLO  = 3'd3,
    ST_RGAP = 3'd4
  } st_e;

  localparam logic [15:0] UNLK_A_HI = 16'h5555;
  localparam logic [15:0] UNLK_A_LO = 16'h2AAA;
  localparam logic [7:0]  KEY_ONE   = 8'hAA;
  localparam logic [7:0]  KEY_TWO   = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
endpackage

// File: rtl/flash_step_gen.sv
module flash_step_gen
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  op_e               op,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  input  logic [ADDR_W-1:0] sect_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data,
  output logic              last_cmd
);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(UNLK_A_HI);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(UNLK_A_LO);

  always_comb begin
    last_cmd = 1'b0;
    case (step)
      3'd0: begin addr = A_HI; data = KEY_ONE; end
      3'd1: begin addr = A_LO; data = KEY_TWO; end
      3'd2: begin addr = A_HI; data = (op == OP_PROG) ? CMD_PROG : CMD_ERASE; end
      3'd3: begin
        if (op == OP_PROG) begin
          addr = tgt_addr; data = tgt_data; last_cmd = 1'b1;
        end else begin
          addr = A_HI; data = KEY_ONE;
        end
      end
      3'd4: begin addr = A_LO; data = KEY_TWO; end
      default: begin
        last_cmd = 1'b1;
        if (op == OP_CHIP) begin addr = A_HI; data = CMD_CHIP; end
        else begin addr = sect_addr; data = CMD_SECT; end
      end
    endcase
  end
endmodule

// File: rtl/flash_sect_pick.sv
module flash_sect_pick #(
  parameter int N_SECT = 8,
  localparam int IDX_W = $clog2(N_SECT)
) (
  input  logic [N_SECT-1:0] mask,
  output logic [N_SECT-1:0] pick_oh,
  output logic [IDX_W-1:0]  pick_idx
);
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    for (int i = N_SECT - 1; i >= 0; i--) begin
      if (mask[i]) begin
        pick_oh        = '0;
        pick_oh[i]     = 1'b1;
        pick_idx       = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_poll_watch.sv
module flash_poll_watch #(
  parameter int LIM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [LIM_W-1:0] limit,
  output logic             reached
);
  logic [LIM_W-1:0] elapsed_q, elapsed_d;
  logic             el_en;

  always_comb begin
    el_en     = clr || (run && (elapsed_q != '1));
    elapsed_d = clr ? '0 : elapsed_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     elapsed_q <= '0;
    else if (el_en) elapsed_q <= elapsed_d;
  end

  assign reached = (elapsed_q >= limit);

  AST_ELAPSED_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> (elapsed_q >= $past(elapsed_q)));  // R7
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int N_SECT  = 8,
  parameter int WE_LO   = 5,
  parameter int WE_HI   = 4,
  parameter int ACC_DLY = 4,
  parameter int RD_GAP  = 2,
  parameter int LIM_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic [N_SECT-1:0] req_sect_mask,
  input  logic [LIM_W-1:0]  cfg_poll_limit,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_i,
  output logic              fl_ce_n,
  output logic              fl_we_n,
  output logic              fl_oe_n
);
  localparam int SECT_W = $clog2(N_SECT);
  localparam int SPAN_W = ADDR_W - SECT_W;
  localparam int M1     = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int M2     = (ACC_DLY > RD_GAP) ? ACC_DLY : RD_GAP;
  localparam int PH_MAX = (M1 > M2) ? M1 : M2;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  st_e               state_q, state_d;
  op_e               op_q, op_d;
  logic [2:0]        step_q, step_d;
  logic [ADDR_W-1:0] addr_q, addr_d, pollad_q, pollad_d;
  logic [7:0]        data_q, data_d;
  logic [N_SECT-1:0] mask_q, mask_d, mask_left;
  logic              exp7_q, exp7_d, done_q, done_d, err_q, err_d;

  logic              tmr_load, tmr_zero, pw_clr, pw_run, pw_reached;
  logic [PH_W-1:0]   tmr_val;
  logic [ADDR_W-1:0] step_addr, sect_base;
  logic [7:0]        step_data;
  logic              step_last;
  logic [N_SECT-1:0] pick_oh;
  logic [SECT_W-1:0] pick_idx;
  logic              unused_low_bits;

  assign unused_low_bits = ^fl_dq_i[6:0];
  assign sect_base       = {pick_idx, {SPAN_W{1'b0}}};
  assign mask_left       = mask_q & ~pick_oh;

  flash_step_gen #(.ADDR_W(ADDR_W)) i_step (
    .op(op_q), .step(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
    .sect_addr(sect_base), .addr(step_addr), .data(step_data), .last_cmd(step_last));

  flash_sect_pick #(.N_SECT(N_SECT)) i_pick (
    .mask(mask_q), .pick_oh(pick_oh), .pick_idx(pick_idx));

  flash_phase_timer #(.CNT_W(PH_W)) i_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  flash_poll_watch #(.LIM_W(LIM_W)) i_pw (
    .clk(clk), .rst_n(rst_n), .clr(pw_clr), .run(pw_run),
    .limit(cfg_poll_limit), .reached(pw_reached));

  assign pw_run = (state_q == ST_RLO) || (state_q == ST_RGAP);

  always_comb begin
    state_d = state_q; op_d = op_q; step_d = step_q; addr_d = addr_q;
    data_d = data_q; mask_d = mask_q; pollad_d = pollad_q; exp7_d = exp7_q;
    done_d = 1'b0; err_d = 1'b0; tmr_load = 1'b0; tmr_val = '0; pw_clr = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid && (req_op != OP_RSVD)) begin
        op_d     = op_e'(req_op);
        addr_d   = req_addr;
        data_d   = req_data;
        pollad_d = req_addr;
        exp7_d   = (req_op == OP_PROG) ? req_data[7] : 1'b1;
        mask_d   = req_sect_mask;
        if (req_sect_mask == '0) begin
          mask_d = '0;
          mask_d[req_addr[ADDR_W-1 -: SECT_W]] = 1'b1;
        end
        step_d = '0; state_d = ST_WLO;
        tmr_load = 1'b1; tmr_val = PH_W'(WE_LO - 1);
      end
      ST_WLO: if (tmr_zero) begin
        state_d = ST_WHI; tmr_load = 1'b1; tmr_val = PH_W'(WE_HI - 1);
      end
      ST_WHI: if (tmr_zero) begin
        if (step_last && (op_q == OP_SECT)) begin
          mask_d = mask_left; pollad_d = sect_base;
        end
        if (step_last && !((op_q == OP_SECT) && (mask_left != '0))) begin
          state_d = ST_RLO; pw_clr = 1'b1;
          tmr_load = 1'b1; tmr_val = PH_W'(ACC_DLY - 1);
        end else begin
          if (!step_last) step_d = step_q + 1'b1;
          state_d = ST_WLO; tmr_load = 1'b1; tmr_val = PH_W'(WE_LO - 1);
        end
      end
      ST_RLO: if (tmr_zero) begin
        if (fl_dq_i[7] == exp7_q) begin
          state_d = ST_IDLE; done_d = 1'b1;
        end else if (pw_reached) begin
          state_d = ST_IDLE; err_d = 1'b1;
        end else begin
          state_d = ST_RGAP; tmr_load = 1'b1; tmr_val = PH_W'(RD_GAP - 1);
        end
      end
      ST_RGAP: if (tmr_zero) begin
        state_d = ST_RLO; tmr_load = 1'b1; tmr_val = PH_W'(ACC_DLY - 1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; op_q <= OP_PROG; step_q <= '0; addr_q <= '0;
      data_q <= '0; mask_q <= '0; pollad_q <= '0; exp7_q <= 1'b0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      state_q <= state_d; op_q <= op_d; step_q <= step_d; addr_q <= addr_d;
      data_q <= data_d; mask_q <= mask_d; pollad_q <= pollad_d; exp7_q <= exp7_d;
      done_q <= done_d; err_q <= err_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
  assign fl_addr  = pw_run ? pollad_q : step_addr;
  assign fl_dq_o  = step_data;
  assign fl_dq_oe = (state_q == ST_WLO) || (state_q == ST_WHI);
  assign fl_we_n  = (state_q != ST_WLO);
  assign fl_oe_n  = (state_q != ST_RLO);
  assign fl_ce_n  = !((state_q == ST_WLO) || (state_q == ST_WHI) || (state_q == ST_RLO));

  // run-length counters used only by the checks below
  logic [7:0] lo_run, hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0; hi_run <= '1;
    end else begin
      lo_run <= fl_we_n ? 8'd0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1);
      hi_run <= !fl_we_n ? 8'd0 : ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1);
    end
  end

  AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (int'(lo_run) >= WE_LO));  // R4
  AST_WE_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> (int'(hi_run) >= WE_HI));  // R4
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fl_we_n) |-> ($stable(fl_addr) && $stable(fl_dq_o)));  // R4
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> (!fl_dq_oe && fl_we_n && !fl_ce_n));  // R5
  AST_END_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> $past(!fl_oe_n));  // R6
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [16:0] req_addr;
  logic [7:0]  req_data;
  logic [7:0]  req_sect_mask;
  logic [31:0] cfg_poll_limit;
  logic        busy, done, err, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
  logic [16:0] fl_addr;
  logic [7:0]  fl_dq_o, fl_dq_i;

  always #4 clk = ~clk;  // 125 MHz

  flash_cmd_seq i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_sect_mask(req_sect_mask),
    .cfg_poll_limit(cfg_poll_limit), .busy(busy), .done(done), .err(err),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash device model
  int          cyc = 0, rd_cnt = 0, wr_cnt = 0, m_busy = 0, tviol = 0, rd_bad = 0;
  logic [7:0]  m_truth = 8'h00;
  logic [16:0] wr_a [16];
  logic [7:0]  wr_d [16];
  logic [16:0] rd_addr = '0;
  int          t_fall = -100, t_rise = -100, t_dq = 0;

  always @(posedge clk) cyc++;
  assign fl_dq_i = (rd_cnt <= m_busy) ? {~m_truth[7], 7'h2B} : {m_truth[7], ~m_truth[6:0]};
  always @(fl_dq_o) t_dq = cyc;
  always @(negedge fl_oe_n) begin
    rd_cnt++;
    rd_addr = fl_addr;
    if (fl_dq_oe || fl_ce_n) rd_bad++;
  end
  always @(negedge fl_we_n) begin
    if (cyc - t_rise < 3 || cyc - t_fall < 9) tviol++;
    t_fall = cyc;
  end
  always @(posedge fl_we_n) begin
    if (rst_n) begin
      if (cyc - t_fall < 5 || cyc - t_dq < 4 || !fl_dq_oe || !fl_oe_n) tviol++;
      if (wr_cnt < 16) begin wr_a[wr_cnt] = fl_addr; wr_d[wr_cnt] = fl_dq_o; end
      wr_cnt++;
      t_rise = cyc;
    end
  end

  // expected write list, built from the requirements
  logic [16:0] exp_a [16];
  logic [7:0]  exp_d [16];
  int          exp_n;
  logic [16:0] exp_poll;

  task automatic build_exp(input logic [1:0] op, input logic [16:0] a,
                           input logic [7:0] d, input logic [7:0] m);
    logic [7:0] mm;
    exp_a[0] = 17'h05555; exp_d[0] = 8'hAA;
    exp_a[1] = 17'h02AAA; exp_d[1] = 8'h55;
    exp_a[2] = 17'h05555; exp_d[2] = (op == 2'd0) ? 8'hA0 : 8'h80;
    exp_poll = a;
    if (op == 2'd0) begin
      exp_a[3] = a; exp_d[3] = d; exp_n = 4;
    end else begin
      exp_a[3] = 17'h05555; exp_d[3] = 8'hAA;
      exp_a[4] = 17'h02AAA; exp_d[4] = 8'h55;
      if (op == 2'd2) begin
        exp_a[5] = 17'h05555; exp_d[5] = 8'h10; exp_n = 6;
      end else begin
        mm = m;
        if (mm == 8'h00) mm = 8'h01 << a[16:14];
        exp_n = 5;
        for (int i = 0; i < 8; i++) if (mm[i]) begin
          exp_a[exp_n] = {3'(i), 14'h0}; exp_d[exp_n] = 8'h30;
          exp_poll = {3'(i), 14'h0};
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [16:0] a, input logic [7:0] d,
                        input logic [7:0] m, input int bz, input logic [31:0] lim,
                        output bit got_done, output bit got_err);
    m_busy = bz; m_truth = (op == 2'd0) ? d : 8'hFF;
    rd_cnt = 0; wr_cnt = 0; tviol = 0; rd_bad = 0;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_sect_mask = m;
    cfg_poll_limit = lim; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 60000 && !(done || err); k++) @(negedge clk);
    got_done = done; got_err = err;
  endtask

  function automatic bit writes_match();
    if (wr_cnt != exp_n) return 0;
    for (int i = 0; i < exp_n; i++)
      if (wr_a[i] != exp_a[i] || wr_d[i] != exp_d[i]) return 0;
    return 1;
  endfunction

  localparam int NV = 8;
  localparam logic [1:0]  V_OP [NV] = '{2'd0, 2'd0, 2'd2, 2'd1, 2'd1, 2'd0, 2'd2, 2'd1};
  localparam logic [16:0] V_AD [NV] = '{17'h12345, 17'h00007, 17'h00000, 17'h1C010,
                                        17'h0ABCD, 17'h1FFFF, 17'h00000, 17'h04000};
  localparam logic [7:0]  V_DT [NV] = '{8'h3C, 8'hC5, 8'h00, 8'h00, 8'h00, 8'h81, 8'h00, 8'h00};
  localparam logic [7:0]  V_MK [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h25, 8'h00, 8'h00, 8'h82};
  localparam int          V_BZ [NV] = '{3, 0, 5, 2, 1, 1000, 0, 50};
  localparam logic [31:0] V_LM [NV] = '{32'd1000, 32'd0, 32'd2000, 32'd1000,
                                        32'd1000, 32'd40, 32'd1, 32'd10};
  localparam bit          V_ER [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  initial begin
    bit gd, ge, saw_busy;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    req_sect_mask = '0; cfg_poll_limit = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !busy && !done && !err,
          "R11 reset outputs", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, busy, done, err}, 7'b1110000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      build_exp(V_OP[v], V_AD[v], V_DT[v], V_MK[v]);
      run_op(V_OP[v], V_AD[v], V_DT[v], V_MK[v], V_BZ[v], V_LM[v], gd, ge);
      check(writes_match(), (V_OP[v] == 2'd0) ? "R1 program writes" :
            (V_OP[v] == 2'd2) ? "R2 chip erase writes" : "R3 sector erase writes",
            wr_cnt, exp_n);
      check(tviol == 0, "R4 write timing", tviol, 0);
      check(rd_addr == exp_poll && rd_bad == 0 && rd_cnt > 0, "R5 poll read", rd_addr, exp_poll);
      if (V_ER[v])
        check(ge && !gd, "R7 timeout", {gd, ge}, 2'b01);
      else if (V_BZ[v] == 0)
        check(gd && !ge, "R8 match wins at limit", {gd, ge}, 2'b10);
      else
        check(gd && !ge, "R6 completion", {gd, ge}, 2'b10);
      @(negedge clk);
      check(!done && !err && !busy, "R9 pulse one clock", {done, err, busy}, 3'b000);
    end

    // R10 reserved request code
    rd_cnt = 0; wr_cnt = 0; saw_busy = 0;
    @(negedge clk);
    req_op = 2'd3; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 30; k++) begin
      if (busy || !fl_ce_n) saw_busy = 1;
      @(negedge clk);
    end
    check(!saw_busy && wr_cnt == 0 && rd_cnt == 0, "R10 reserved code ignored", wr_cnt, 0);

    // R9 request while busy is ignored
    build_exp(2'd0, 17'h0F0F0, 8'h5A, 8'h00);
    m_busy = 2; m_truth = 8'h5A; rd_cnt = 0; wr_cnt = 0; tviol = 0;
    @(negedge clk);
    req_op = 2'd0; req_addr = 17'h0F0F0; req_data = 8'h5A; cfg_poll_limit = 32'd500;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    saw_busy = busy;
    req_op = 2'd2; req_addr = 17'h00000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 60000 && !(done || err); k++) @(negedge clk);
    check(saw_busy, "R9 busy during operation", saw_busy, 1);
    check(done && writes_match(), "R9 busy request ignored", wr_cnt, exp_n);
    repeat (40) @(negedge clk);
    check(!busy && wr_cnt == exp_n, "R9 no late start", wr_cnt, exp_n);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule